// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers ten interrupt sources into one level interrupt line, and software manages it over a 32-bit APB register bus. A status register records pending sources. Hardware event pulses set status bits, and software sets them through a trigger register. Software clears a status bit by writing 1 to it.

A mask register decides which pending sources reach the output line. Software can read the mask, but a direct write to it has no effect. The mask changes only through two write-only strobe registers: one unmasks bits and the other masks them. The output line is registered. It reflects the new status and mask from the same clock edge that commits a write or an event.

Register word offsets are: status 0x00, mask 0x04, unmask strobe 0x08, mask strobe 0x0C, trigger 0x10. Any other offset reads as zero and ignores writes. A write is committed in the APB access phase (`psel` and `penable` both high). Read data is captured at the end of the setup phase and is held through the access phase. `pready` is always high.

Top module: `irq_status_mask_ctrl`

## Requirements
- R1: Bits [31:10] of every register read back as zero, and writing ones to them changes nothing.
- R2: A full write to the status register (offset 0x00) clears each status bit whose data bit is 1 and leaves the others unchanged.
- R3: The mask register (offset 0x04) resets to 0x3FF, and a direct write to it leaves it unchanged.
- R4: A write to the unmask strobe register (offset 0x08) clears the mask bits at the positions written as 1.
- R5: A write to the mask strobe register (offset 0x0C) sets the mask bits at the positions written as 1.
- R6: A write to the trigger register (offset 0x10) sets the status bits at the positions written as 1.
- R7: `irq_o` is high exactly when (status AND NOT mask) is non-zero. It takes its new value at the same clock edge that updates status or mask.
- R8: The unmask strobe, mask strobe and trigger registers read back as zero.
- R9: If a hardware event sets a status bit in the same cycle that a status write clears it, the bit ends up set.
- R10: A write whose byte strobes `pstrb` are not all ones (4'b1111) is ignored by every register.
- R11: An event bit that is high on `hw_event` in a cycle sets the matching status bit at the next clock edge.
- R12: After reset, status is zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes; only 4'b1111 writes are accepted |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always high: no wait states |
| hw_event | input | NSRC (10) | Hardware event inputs, one per source |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bound checker checks these rules on every cycle:
- the interrupt line matches status and mask;
- the mask stays fixed unless a strobe write is accepted;
- events always set their bits, even against a clearing write;
- triggers take effect;
- partial-strobe writes leave the state untouched;
- reserved read bits stay zero.

The bench's scenarios show the rest, using a reference model: the exact clear and set patterns per register, the zero readback of the strobe registers, and the reset values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register selected by the word index of the bus address
  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_UNMASK  = 3'd2,
    SEL_MASKSET = 3'd3,
    SEL_TRIGGER = 3'd4,
    SEL_NONE    = 3'd7
  } reg_sel_e;

  localparam int unsigned WORD_STATUS  = 0;
  localparam int unsigned WORD_MASK    = 1;
  localparam int unsigned WORD_UNMASK  = 2;
  localparam int unsigned WORD_MASKSET = 3;
  localparam int unsigned WORD_TRIGGER = 4;
endpackage

// File: rtl/irqc_bus_port.sv
module irqc_bus_port
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NSRC-1:0]   wdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [NSRC-1:0]   status_q,
  input  logic [NSRC-1:0]   mask_q,
  output logic [DATA_W-1:0] prdata,
  output logic [NSRC-1:0]   clr_vec,
  output logic [NSRC-1:0]   unmask_vec,
  output logic [NSRC-1:0]   maskset_vec,
  output logic [NSRC-1:0]   trig_vec
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  reg_sel_e         sel;
  logic             wr_ok;
  logic             rd_setup;
  logic [DATA_W-1:0] rd_word;

  assign widx = paddr[ADDR_W-1:2];

  // Unaligned offsets select nothing
  always_comb begin
    sel = SEL_NONE;
    if (paddr[1:0] == 2'b00) begin
      if      (widx == IDX_W'(WORD_STATUS))  sel = SEL_STATUS;
      else if (widx == IDX_W'(WORD_MASK))    sel = SEL_MASK;
      else if (widx == IDX_W'(WORD_UNMASK))  sel = SEL_UNMASK;
      else if (widx == IDX_W'(WORD_MASKSET)) sel = SEL_MASKSET;
      else if (widx == IDX_W'(WORD_TRIGGER)) sel = SEL_TRIGGER;
    end
  end

  // Only full-word writes in the access phase commit
  assign wr_ok    = psel && penable && pwrite && (pstrb == '1);
  assign rd_setup = psel && !penable && !pwrite;

  assign clr_vec     = (wr_ok && sel == SEL_STATUS)  ? wdata : '0;
  assign unmask_vec  = (wr_ok && sel == SEL_UNMASK)  ? wdata : '0;
  assign maskset_vec = (wr_ok && sel == SEL_MASKSET) ? wdata : '0;
  assign trig_vec    = (wr_ok && sel == SEL_TRIGGER) ? wdata : '0;

  always_comb begin
    case (sel)
      SEL_STATUS: rd_word = DATA_W'(status_q);
      SEL_MASK:   rd_word = DATA_W'(mask_q);
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_word;
  end
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
  parameter int unsigned NSRC = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] sw_set,
  output logic [NSRC-1:0] status_d,
  output logic [NSRC-1:0] status_q
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    // Set has priority over clear
    assign status_d[b] = (status_q[b] & ~clr_vec[b]) | hw_set[b] | sw_set[b];

    always_ff @(posedge clk) begin
      if (rst) status_q[b] <= 1'b0;
      else     status_q[b] <= status_d[b];
    end
  end
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int unsigned NSRC = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] unmask_vec,
  input  logic [NSRC-1:0] maskset_vec,
  output logic [NSRC-1:0] mask_d,
  output logic [NSRC-1:0] mask_q
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    assign mask_d[b] = (mask_q[b] | maskset_vec[b]) & ~unmask_vec[b];

    always_ff @(posedge clk) begin
      if (rst) mask_q[b] <= 1'b1;
      else     mask_q[b] <= mask_d[b];
    end
  end
endmodule

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl #(
  parameter int unsigned NSRC   = 10,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  input  logic [NSRC-1:0]     hw_event,
  output logic                irq_o
);
  logic [NSRC-1:0] status_q, status_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] clr_vec, unmask_vec, maskset_vec, trig_vec;

  assign pready = 1'b1;

  irqc_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) bus_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .wdata(pwdata[NSRC-1:0]), .pstrb(pstrb),
    .status_q(status_q), .mask_q(mask_q), .prdata(prdata),
    .clr_vec(clr_vec), .unmask_vec(unmask_vec), .maskset_vec(maskset_vec),
    .trig_vec(trig_vec)
  );

  irqc_status_bank #(.NSRC(NSRC)) status_i (
    .clk(clk), .rst(rst), .clr_vec(clr_vec), .hw_set(hw_event),
    .sw_set(trig_vec), .status_d(status_d), .status_q(status_q)
  );

  irqc_mask_bank #(.NSRC(NSRC)) mask_i (
    .clk(clk), .rst(rst), .unmask_vec(unmask_vec), .maskset_vec(maskset_vec),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  // Registered from next-state values so the line moves with the registers
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_d & ~mask_d);
  end
endmodule

// File: rtl/irqc_sva.sv
module irqc_sva #(
  parameter int unsigned NSRC   = 10,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W/8-1:0] pstrb,
  input logic [DATA_W-1:0]   prdata,
  input logic [NSRC-1:0]     hw_event,
  input logic                irq_o,
  input logic [NSRC-1:0]     status_q,
  input logic [NSRC-1:0]     mask_q
);
  logic acc_wr, full_wr, word_ok;
  assign acc_wr  = psel && penable && pwrite;
  assign full_wr = acc_wr && (pstrb == '1);
  assign word_ok = (paddr[1:0] == 2'b00);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & ~mask_q));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!full_wr || (word_ok && paddr[ADDR_W-1:2] == (ADDR_W-2)'(1))) |=> $stable(mask_q));

  p_event_sets_r11: assert property (@(posedge clk) disable iff (rst)
    (|hw_event) |=> ((status_q & $past(hw_event)) == $past(hw_event)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (full_wr && word_ok && paddr[ADDR_W-1:2] == '0 && |(pwdata[NSRC-1:0] & hw_event))
    |=> ((status_q & $past(hw_event)) == $past(hw_event)));

  p_trigger_r6: assert property (@(posedge clk) disable iff (rst)
    (full_wr && word_ok && paddr[ADDR_W-1:2] == (ADDR_W-2)'(4))
    |=> ((status_q & $past(pwdata[NSRC-1:0])) == $past(pwdata[NSRC-1:0])));

  p_narrow_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && pstrb != '1 && hw_event == '0)
    |=> ($stable(status_q) && $stable(mask_q)));

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    prdata[DATA_W-1:NSRC] == '0);

  p_rsvd_data_r1: assert property (@(posedge clk) disable iff (rst)
    (full_wr && pwdata[DATA_W-1:NSRC] != '0 && pwdata[NSRC-1:0] == '0 && hw_event == '0)
    |=> ($stable(status_q) && $stable(mask_q)));
endmodule

bind irq_status_mask_ctrl irqc_sva #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) sva_i (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
  .hw_event(hw_event), .irq_o(irq_o), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/irq_status_mask_ctrl_tb.sv
module irq_status_mask_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0] pstrb = '0;
  logic [31:0] prdata;
  logic pready;
  logic [NSRC-1:0] hw_event = '0;
  logic irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_mask_ctrl dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .hw_event(hw_event), .irq_o(irq_o)
  );

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t sb_q[$];
  int checks = 0, errors = 0;
  logic [NSRC-1:0] m_status = '0;
  logic [NSRC-1:0] m_mask = '1;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return 32'(m_status);
      8'h04:   return 32'(m_mask);
      default: return 32'h0;
    endcase
  endfunction

  // Monitor: compare read data in the access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", prdata);
      end else begin
        e = sb_q.pop_front();
        if (prdata !== e.val) begin
          errors++;
          $display("FAIL %s: read actual %h expected %h", e.req, prdata, e.val);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                           input logic [3:0] st, input logic [NSRC-1:0] ev);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = st;
    @(posedge clk); #1;
    penable = 1; hw_event = ev;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0; hw_event = '0;
    if (st == 4'hF) begin
      case (a)
        8'h00: m_status = m_status & ~d[NSRC-1:0];
        8'h08: m_mask = m_mask & ~d[NSRC-1:0];
        8'h0C: m_mask = m_mask | d[NSRC-1:0];
        8'h10: m_status = m_status | d[NSRC-1:0];
        default: ;
      endcase
    end
    m_status = m_status | ev;
  endtask

  task automatic bus_read(input logic [7:0] a, input string req);
    exp_t e;
    e.val = exp_read(a); e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a; pstrb = 4'hF;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic pulse_event(input logic [NSRC-1:0] ev);
    @(posedge clk); #1; hw_event = ev;
    @(posedge clk); #1; hw_event = '0;
    m_status = m_status | ev;
  endtask

  task automatic check_irq(input string req);
    logic exp;
    @(negedge clk);
    exp = |(m_status & ~m_mask);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o actual %b expected %b", req, irq_o, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check_irq("R12 reset irq");
    bus_read(8'h00, "R12 reset status");
    bus_read(8'h04, "R3 reset mask");
    // R3: direct mask write ignored
    bus_write(8'h04, 32'h0, 4'hF, '0);
    bus_read(8'h04, "R3 direct write");
    // R6 trigger, masked so no irq
    bus_write(8'h10, 32'h005, 4'hF, '0);
    bus_read(8'h00, "R6 trigger");
    check_irq("R7 masked");
    // R4 unmask bit 0
    bus_write(8'h08, 32'h001, 4'hF, '0);
    bus_read(8'h04, "R4 unmask");
    check_irq("R7 unmasked pending");
    // R8 strobe registers read zero
    bus_read(8'h08, "R8 unmask read");
    bus_read(8'h0C, "R8 maskset read");
    bus_read(8'h10, "R8 trigger read");
    // R5 mask bit 0 again
    bus_write(8'h0C, 32'h001, 4'hF, '0);
    bus_read(8'h04, "R5 maskset");
    check_irq("R7 remasked");
    // R2 clear bit 0 with reserved bits set (R1)
    bus_write(8'h00, 32'hFFFFFC01, 4'hF, '0);
    bus_read(8'h00, "R2 clear one bit R1");
    // R11 hardware event
    pulse_event(10'h200);
    bus_read(8'h00, "R11 event");
    // R10 narrow writes ignored
    bus_write(8'h00, 32'h3FF, 4'h3, '0);
    bus_read(8'h00, "R10 narrow status");
    bus_write(8'h08, 32'h3FF, 4'h1, '0);
    bus_read(8'h04, "R10 narrow unmask");
    // R9 event wins over clear
    bus_write(8'h08, 32'h3FF, 4'hF, '0);
    check_irq("R7 all unmasked");
    bus_write(8'h00, 32'h204, 4'hF, 10'h004);
    bus_read(8'h00, "R9 set wins");
    check_irq("R9 irq kept");
    bus_write(8'h00, 32'h004, 4'hF, '0);
    check_irq("R7 cleared");
    // R1 trigger all ones, reserved reads zero
    bus_write(8'h10, 32'hFFFFFFFF, 4'hF, '0);
    bus_read(8'h00, "R1 reserved status");
    bus_read(8'h04, "R1 reserved mask");
    check_irq("R7 triggered");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule